// File: doc/BRIEF.md
# Power-Fail Supervisor and Supply Switchover Sequencer

This block watches a memory or clock device's main supply. Two analog comparators outside the block report the supply level as digital flags. One flag says the supply has dropped under the power-fail level. The other says it has dropped further, under the level at which the device should switch to its backup battery. The sequencer filters both flags and drives three controls:

- a write-protect level that blocks accesses from a failing host;
- a single-cycle abort pulse that ends any transfer in progress and clears the access address pointer;
- battery-select and low-power controls for the supply switch.

Protection begins at the upper level. The supply switch happens only at the lower level. On the way back up, the battery is released as soon as the supply is above the switchover level. Write protection is held until the supply is above the power-fail level and a programmable recovery time has passed. Each flag goes through a synchronizer and a stability filter before the control logic acts on it. Every delay is a parameter counted in clock cycles.

Top module: `pwr_fail_seq`

## Requirements
- R1: While reset is asserted and right after reset, wr_prot_o, acc_abort_o, bat_sel_o and low_pwr_o are all 0.
- R2: A change on a supply flag takes effect only after it has held for STABLE_CYC consecutive cycles after the SYNC_STAGES synchronizer. A pulse shorter than that, in either direction, has no effect on any output.
- R3: When below_pf_i rises and stays high, wr_prot_o goes to 1 exactly SYNC_STAGES+STABLE_CYC+1 cycles after the input change. In that same first protected cycle acc_abort_o is 1, and only in that cycle. acc_abort_o also serves as the address pointer reset request.
- R4: When below_so_i rises while protection is active, bat_sel_o and low_pwr_o go to 1 SYNC_STAGES+STABLE_CYC+1 cycles later, and wr_prot_o stays 1.
- R5: When below_so_i falls while the battery is selected, bat_sel_o and low_pwr_o return to 0 after the same latency. wr_prot_o stays 1, and acc_abort_o gives its one-cycle pulse again because the protected state is re-entered.
- R6: After below_pf_i falls with below_so_i low, wr_prot_o stays 1 for exactly REC_CYC cycles after the recovery phase begins. The recovery phase begins SYNC_STAGES+STABLE_CYC+1 cycles after the input change. wr_prot_o then drops to 0.
- R7: A filtered supply drop during the recovery phase returns the block to the protected state, with a new abort pulse. The recovery count restarts from zero on the next recovery entry, so the full REC_CYC cycles are needed again.
- R8: bat_sel_o and low_pwr_o are never 1 while wr_prot_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| below_pf_i | input | 1 | Comparator flag: supply under the power-fail level |
| below_so_i | input | 1 | Comparator flag: supply under the battery switchover level |
| wr_prot_o | output | 1 | Write-protect level |
| acc_abort_o | output | 1 | One-cycle access abort and address pointer reset request |
| bat_sel_o | output | 1 | Select the backup battery as supply |
| low_pwr_o | output | 1 | Enter the low-current mode |

## Verification
The bench checks each transition exactly on its latency cycle and also one cycle earlier. An extra register in the flag path, or a missing one, therefore shows up as an early or late edge. A short power-fail pulse during normal operation and another during recovery must both be ignored. A filter that reacts to single samples would raise protection spuriously, or would stretch the recovery window. A real drop part-way through recovery, followed by a second recovery, is timed against the full recovery length. A counter that is not cleared would release write protection early. Leaving the battery state must fire a fresh abort pulse. A design that holds the abort as a level, or skips it on that path, is caught there.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
   typedef enum logic [1:0] {
      ST_NORMAL  = 2'd0,
      ST_PROTECT = 2'd1,
      ST_BATTERY = 2'd2,
      ST_RECOVER = 2'd3
   } pfs_state_e;

   localparam int FLAG_PF   = 0;
   localparam int FLAG_SO   = 1;
   localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/pfs_filter.sv
module pfs_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int STABLE_CYC  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic flt_o
);
   localparam int CW = (STABLE_CYC < 2) ? 1 : $clog2(STABLE_CYC + 1);
   localparam logic [CW-1:0] CNT_LAST = CW'(STABLE_CYC - 1);

   initial begin
      assert (SYNC_STAGES >= 0) else $error("pfs_filter: SYNC_STAGES must be >= 0");
      assert (STABLE_CYC >= 1) else $error("pfs_filter: STABLE_CYC must be >= 1");
   end

   logic sync_w;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign sync_w = raw_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q[0] <= raw_i;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  chain_q[i] <= chain_q[i-1];
               end
            end
         end
         assign sync_w = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          flt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         flt_q <= 1'b0;
      end else if (sync_w == flt_q) begin
         cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
         cnt_q <= '0;
         flt_q <= sync_w;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign flt_o = flt_q;

   AST_FLT_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(flt_q) |-> (flt_q == $past(sync_w))); // R2
   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_LAST); // R2
endmodule

// File: rtl/pfs_rec_timer.sv
module pfs_rec_timer #(
   parameter int REC_CYC = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic done_o
);
   localparam int CW = (REC_CYC < 2) ? 1 : $clog2(REC_CYC + 1);
   localparam logic [CW-1:0] CNT_LAST = CW'(REC_CYC - 1);

   initial begin
      assert (REC_CYC >= 1) else $error("pfs_rec_timer: REC_CYC must be >= 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i) begin
         cnt_q <= '0;
      end else if (cnt_q != CNT_LAST) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done_o = run_i && (cnt_q == CNT_LAST);

   AST_REC_CLEARED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(run_i) |-> (cnt_q == '0)); // R7
   AST_REC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_LAST); // R6
endmodule

// File: rtl/pfs_ctrl.sv
module pfs_ctrl
   import pfs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic below_pf_i,
   input  logic below_so_i,
   input  logic rec_done_i,
   output logic rec_run_o,
   output logic wr_prot_o,
   output logic acc_abort_o,
   output logic bat_sel_o,
   output logic low_pwr_o
);
   pfs_state_e st_q, st_nxt;
   logic       abort_q;

   always_comb begin
      st_nxt = st_q;
      unique case (st_q)
         ST_NORMAL:  if (below_pf_i || below_so_i) st_nxt = ST_PROTECT;
         ST_PROTECT: begin
            if (below_so_i)       st_nxt = ST_BATTERY;
            else if (!below_pf_i) st_nxt = ST_RECOVER;
         end
         ST_BATTERY: if (!below_so_i) st_nxt = ST_PROTECT;
         ST_RECOVER: begin
            if (below_pf_i || below_so_i) st_nxt = ST_PROTECT;
            else if (rec_done_i)          st_nxt = ST_NORMAL;
         end
         default: st_nxt = ST_PROTECT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_NORMAL;
         abort_q <= 1'b0;
      end else begin
         st_q    <= st_nxt;
         abort_q <= (st_nxt == ST_PROTECT) && (st_q != ST_PROTECT);
      end
   end

   assign rec_run_o   = (st_q == ST_RECOVER);
   assign wr_prot_o   = (st_q != ST_NORMAL);
   assign acc_abort_o = abort_q;
   assign bat_sel_o   = (st_q == ST_BATTERY);
   assign low_pwr_o   = (st_q == ST_BATTERY);

   AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      acc_abort_o |=> !acc_abort_o); // R3
   AST_ABORT_IN_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
      acc_abort_o |-> (st_q == ST_PROTECT)); // R3
   AST_BAT_NEEDS_PROT: assert property (@(posedge clk) disable iff (!rst_n)
      (bat_sel_o || low_pwr_o) |-> wr_prot_o); // R8
   AST_RECOVER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RECOVER && below_pf_i) |=> (st_q == ST_PROTECT)); // R7
   AST_BAT_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_BATTERY && !below_so_i) |=> (st_q == ST_PROTECT && acc_abort_o)); // R5
endmodule

// File: rtl/pwr_fail_seq.sv
module pwr_fail_seq #(
   parameter int SYNC_STAGES = 2,
   parameter int STABLE_CYC  = 4,
   parameter int REC_CYC     = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic below_pf_i,
   input  logic below_so_i,
   output logic wr_prot_o,
   output logic acc_abort_o,
   output logic bat_sel_o,
   output logic low_pwr_o
);
   import pfs_pkg::*;

   logic [NUM_FLAGS-1:0] raw_w;
   logic [NUM_FLAGS-1:0] flt_w;
   logic                 rec_run_w;
   logic                 rec_done_w;

   assign raw_w[FLAG_PF] = below_pf_i;
   assign raw_w[FLAG_SO] = below_so_i;

   generate
      for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
         pfs_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .STABLE_CYC (STABLE_CYC)
         ) u_filter (
            .clk  (clk),
            .rst_n(rst_n),
            .raw_i(raw_w[g]),
            .flt_o(flt_w[g])
         );
      end
   endgenerate

   pfs_rec_timer #(
      .REC_CYC(REC_CYC)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (rec_run_w),
      .done_o(rec_done_w)
   );

   pfs_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .below_pf_i (flt_w[FLAG_PF]),
      .below_so_i (flt_w[FLAG_SO]),
      .rec_done_i (rec_done_w),
      .rec_run_o  (rec_run_w),
      .wr_prot_o  (wr_prot_o),
      .acc_abort_o(acc_abort_o),
      .bat_sel_o  (bat_sel_o),
      .low_pwr_o  (low_pwr_o)
   );

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> !(wr_prot_o || acc_abort_o || bat_sel_o || low_pwr_o)); // R1
endmodule

// File: tb/pwr_fail_seq_test.sv
module pwr_fail_seq_test;
   localparam int SYNC = 2;
   localparam int STAB = 4;
   localparam int REC  = 20;
   localparam int LAT  = SYNC + STAB + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic below_pf = 1'b0;
   logic below_so = 1'b0;
   logic wr_prot, acc_abort, bat_sel, low_pwr;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      int         at;
      logic [3:0] val;
      string      tag;
   } exp_t;
   exp_t sb_q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pwr_fail_seq #(.SYNC_STAGES(SYNC), .STABLE_CYC(STAB), .REC_CYC(REC)) uut (
      .clk(clk), .rst_n(rst_n), .below_pf_i(below_pf), .below_so_i(below_so),
      .wr_prot_o(wr_prot), .acc_abort_o(acc_abort),
      .bat_sel_o(bat_sel), .low_pwr_o(low_pwr)
   );

   // expected vector: {wr_prot, acc_abort, bat_sel, low_pwr}
   task automatic expect_at(input int at, input logic [3:0] v, input string tag);
      exp_t e;
      e.at = at; e.val = v; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic wait_cyc(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   // monitor: pops and compares
   always @(negedge clk) begin
      logic [3:0] act;
      act = {wr_prot, acc_abort, bat_sel, low_pwr};
      while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
         exp_t e;
         e = sb_q.pop_front();
         checks++;
         if (e.at < cyc) begin
            errors++;
            $display("FAIL %s: check for cycle %0d missed at cycle %0d, actual %b expected %b",
                     e.tag, e.at, cyc, act, e.val);
         end else if (act !== e.val) begin
            errors++;
            $display("FAIL %s: cycle %0d actual %b expected %b", e.tag, cyc, act, e.val);
         end
      end
   end

   initial begin
      // R1: reset state, during and after reset
      expect_at(2, 4'b0000, "R1");
      expect_at(6, 4'b0000, "R1");
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R2: 3-cycle glitch on the power-fail flag is ignored
      wait_cyc(10);
      expect_at(10 + LAT, 4'b0000, "R2");
      expect_at(10 + LAT + 2, 4'b0000, "R2");
      expect_at(10 + LAT + 5, 4'b0000, "R2");
      below_pf = 1'b1;
      wait_cyc(13);
      below_pf = 1'b0;

      // R3: power fail -> protect level + single abort pulse
      wait_cyc(30);
      expect_at(30 + LAT - 1, 4'b0000, "R3");
      expect_at(30 + LAT, 4'b1100, "R3");
      expect_at(30 + LAT + 1, 4'b1000, "R3");
      below_pf = 1'b1;

      // R4: switchover -> battery + low power
      wait_cyc(50);
      expect_at(50 + LAT - 1, 4'b1000, "R4");
      expect_at(50 + LAT, 4'b1011, "R4");
      below_so = 1'b1;

      // R5: back above switchover -> battery off, still protected, new abort
      wait_cyc(70);
      expect_at(70 + LAT - 1, 4'b1011, "R5");
      expect_at(70 + LAT, 4'b1100, "R5");
      expect_at(70 + LAT + 1, 4'b1000, "R5");
      below_so = 1'b0;

      // R6: recovery time after the supply is good again
      wait_cyc(90);
      expect_at(90 + LAT, 4'b1000, "R6");
      expect_at(90 + LAT + REC - 1, 4'b1000, "R6");
      expect_at(90 + LAT + REC, 4'b0000, "R6");
      below_pf = 1'b0;

      // R2/R6: glitch during recovery does not disturb the window
      wait_cyc(140);
      below_pf = 1'b1;
      wait_cyc(160);
      expect_at(160 + LAT, 4'b1000, "R6");
      expect_at(180, 4'b1000, "R2");
      expect_at(160 + LAT + REC - 1, 4'b1000, "R2");
      expect_at(160 + LAT + REC, 4'b0000, "R2");
      below_pf = 1'b0;
      wait_cyc(172);
      below_pf = 1'b1;
      wait_cyc(174);
      below_pf = 1'b0;

      // R7: real drop during recovery, then the full window again
      wait_cyc(220);
      below_pf = 1'b1;
      wait_cyc(240);
      expect_at(240 + LAT, 4'b1000, "R7");
      expect_at(257 + LAT - 1, 4'b1000, "R7");
      expect_at(257 + LAT, 4'b1100, "R7");
      expect_at(257 + LAT + 1, 4'b1000, "R7");
      expect_at(270 + LAT + REC - 1, 4'b1000, "R7");
      expect_at(270 + LAT + REC, 4'b0000, "R7");
      below_pf = 1'b0;
      wait_cyc(257);
      below_pf = 1'b1;
      wait_cyc(270);
      below_pf = 1'b0;

      // R8: battery only with protection, one more switchover cycle
      wait_cyc(320);
      below_pf = 1'b1;
      below_so = 1'b1;
      expect_at(320 + LAT, 4'b1100, "R8");
      expect_at(320 + LAT + 1, 4'b1011, "R8");
      wait_cyc(340);
      below_so = 1'b0;
      below_pf = 1'b0;
      expect_at(340 + LAT, 4'b1100, "R8");
      expect_at(340 + LAT + 1, 4'b1000, "R8");
      expect_at(340 + LAT + 1 + REC, 4'b0000, "R8");

      wait_cyc(400);
      while (sb_q.size() > 0) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run hung at cycle %0d, actual running expected finished", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule